// File: doc/BRIEF.md
# Snapshot-Delta On-Delay Timer

This block is an on-delay timer record that advances only when it is evaluated. A control program scans the timer instruction, and each scan shows up here as a one-cycle evaluation strobe that carries the rung condition. The record holds an accumulator, a preset and a control word. The low byte of the control word keeps a copy of a free-running tick counter, taken at the previous evaluation.

At each enabled evaluation the timer finds the ticks that have passed since that copy. It takes the difference of the two low bytes modulo 256, adds that difference to the accumulator, saturating at full scale, and then takes a fresh copy. It then updates the done and timing flags. An evaluation with the rung condition false resets the record.

The tick counter comes from a prescaler. With the default count it advances every 10 ms at 125 MHz. Software reaches the record through a small read/write register port.

Top module: `snap_delta_timer`

## Requirements
- R1: After reset the accumulator, the preset, the snapshot byte, the tick counter and all three flags (enabled, timing, done) are zero.
- R2: The tick counter (`tick_o`) advances by exactly one every PRESCALE clock cycles.
- R3: The first evaluation with the rung condition true, made while the enabled flag is clear, sets the enabled flag. It stores the tick counter's low byte, as sampled in the strobe cycle, as the snapshot. The accumulator is left unchanged.
- R4: A later evaluation with the rung condition true, made while the enabled flag is set, adds (tick low byte − snapshot) mod 256 to the accumulator. It then replaces the snapshot with the current tick low byte.
- R5: After each evaluation the done flag equals (accumulator ≥ preset), using the updated accumulator. The timing flag equals enabled AND NOT done. The accumulator may overshoot the preset by several ticks.
- R6: An evaluation with the rung condition false clears the accumulator and the enabled, timing and done flags. It keeps the snapshot byte.
- R7: The accumulator and the flags change only at an evaluation strobe. Writing the preset between strobes does not change them.
- R8: The accumulator saturates at 2^ACC_W−1 instead of wrapping.
- R9: A gap longer than 255 ticks between evaluations aliases. Only (gap mod 256) ticks are added.
- R10: Register map on 2-bit addresses:
  - Address 0 reads the control word: bit 15 enabled, bit 14 timing, bit 13 done, bits 7:0 snapshot, all other bits zero.
  - Address 1 reads the preset, zero-extended.
  - Address 2 reads the accumulator, zero-extended.
  - Address 3 reads the low 16 bits of the tick counter.
  - Only writes to address 1 take effect; they load the low ACC_W bits into the preset. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_stb | input | 1 | One-cycle evaluation strobe (timer instruction scanned) |
| rung_en | input | 1 | Rung condition, sampled with `eval_stb` |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tick_o | output | TICK_W | Free-running tick counter |
| done_o | output | 1 | Done flag |
| timing_o | output | 1 | Timing flag |

## Verification
The embedded assertions check four rules on every cycle:
- the accumulator and the done flag hold between strobes;
- a disabled evaluation empties the record;
- an enabled evaluation never lowers the accumulator;
- the snapshot always follows the tick byte seen at the strobe, and the tick counter never steps by more than one.

The exact amount added per evaluation needs the bench's scenarios, which compare against a reference model. These include the modulo-256 aliasing of long gaps, saturation at full scale, the done/timing relation against a changing preset, and the register map.

// File: rtl/snap_delta_timer.sv
module snap_delta_timer #(
  parameter int PRESCALE = 1250000,
  parameter int TICK_W   = 16,
  parameter int ACC_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_stb,
  input  logic              rung_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic [TICK_W-1:0] tick_o,
  output logic              done_o,
  output logic              timing_o
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [PS_W-1:0]   ps_cnt;
  logic [TICK_W-1:0] tick_cnt;
  logic [ACC_W-1:0]  acc_q, pre_q, acc_nxt;
  logic [7:0]        snap_q, delta;
  logic              en_q, dn_q;
  logic [ACC_W:0]    sum;

  wire tick_pulse = (ps_cnt == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_cnt   <= '0;
      tick_cnt <= '0;
    end else begin
      ps_cnt   <= tick_pulse ? '0 : ps_cnt + 1'b1;
      tick_cnt <= tick_cnt + TICK_W'(tick_pulse);
    end
  end

  assign delta   = tick_cnt[7:0] - snap_q;
  assign sum     = {1'b0, acc_q} + (ACC_W+1)'(delta);
  assign acc_nxt = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pre_q  <= '0;
      snap_q <= '0;
      en_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 2'd1) pre_q <= wr_data[ACC_W-1:0];
      if (eval_stb) begin
        if (!rung_en) begin
          acc_q <= '0;
          en_q  <= 1'b0;
          dn_q  <= 1'b0;
        end else if (!en_q) begin
          en_q   <= 1'b1;
          snap_q <= tick_cnt[7:0];
          dn_q   <= (acc_q >= pre_q);
        end else begin
          acc_q  <= acc_nxt;
          snap_q <= tick_cnt[7:0];
          dn_q   <= (acc_nxt >= pre_q);
        end
      end
    end
  end

  assign tick_o   = tick_cnt;
  assign done_o   = dn_q;
  assign timing_o = en_q & ~dn_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {en_q, timing_o, dn_q, 5'b0, snap_q};
      2'd1:    rd_data = 16'(pre_q);
      2'd2:    rd_data = 16'(acc_q);
      default: rd_data = 16'(tick_cnt);
    endcase
  end

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tick_cnt == $past(tick_cnt)) || (tick_cnt == $past(tick_cnt) + 1'b1));

  // R4
  snap_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb && rung_en |=> snap_q == $past(tick_cnt[7:0]));

  // R6
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb && !rung_en |=> acc_q == '0 && !dn_q && !timing_o);

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb |=> $stable(acc_q) && $stable(dn_q) && $stable(en_q));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb && rung_en && en_q |=> acc_q >= $past(acc_q));

endmodule

// File: tb/snap_delta_timer_tb.sv
module snap_delta_timer_tb;
  localparam int PS = 3;
  localparam int TW = 16;
  localparam int AW = 12;
  localparam int MAXV = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic eval_stb = 0, rung_en = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [TW-1:0] tick_o;
  logic done_o, timing_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_acc = 0, m_pre = 0, m_snap = 0;
  bit m_en = 0, m_dn = 0;

  always #4 clk = ~clk;

  snap_delta_timer #(.PRESCALE(PS), .TICK_W(TW), .ACC_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .rung_en(rung_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tick_o(tick_o), .done_o(done_o), .timing_o(timing_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int ctrl_exp();
    bit tt = m_en && !m_dn;
    return (int'(m_en) << 15) | (int'(tt) << 14) | (int'(m_dn) << 13) | m_snap;
  endfunction

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic check_all(input string req);
    int v;
    rd(2'd2, v); chk({req, " acc"}, v, m_acc);
    rd(2'd0, v); chk({req, " ctrl"}, v, ctrl_exp());
    chk({req, " done_o"}, int'(done_o), int'(m_dn));
    chk({req, " timing_o"}, int'(timing_o), int'(m_en && !m_dn));
  endtask

  task automatic do_eval(input bit en);
    int t, s;
    @(negedge clk);
    eval_stb = 1; rung_en = en;
    t = int'(tick_o[7:0]);
    if (!en) begin
      m_acc = 0; m_en = 0; m_dn = 0;
    end else if (!m_en) begin
      m_en = 1; m_snap = t; m_dn = (m_acc >= m_pre);
    end else begin
      s = m_acc + ((t - m_snap) & 255);
      if (s > MAXV) s = MAXV;
      m_acc = s; m_snap = t; m_dn = (m_acc >= m_pre);
    end
    @(negedge clk);
    eval_stb = 0; rung_en = 0;
  endtask

  task automatic do_write(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = 16'(d);
    if (a == 2'd1) m_pre = d & MAXV;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * PS) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    int v, t0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, v); chk("R1 acc", v, 0);
    rd(2'd1, v); chk("R1 preset", v, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 timing", int'(timing_o), 0);

    // R2 tick rate
    t0 = int'(tick_o);
    repeat (10 * PS) @(negedge clk);
    chk("R2 tick step", int'(tick_o) - t0, 10);
    rd(2'd3, v); chk("R10 tick readback", v, int'(tick_o));

    // R10 preset write and width truncation
    do_write(2'd1, 16'hF020);
    rd(2'd1, v); chk("R10 preset", v, 16'h020);

    // R3 first enabled evaluation
    wait_ticks(5);
    do_eval(1);
    check_all("R3");

    // R4 later evaluations with various gaps
    wait_ticks(7);   do_eval(1); check_all("R4 gap7");
    wait_ticks(1);   do_eval(1); check_all("R4 gap1");
    do_eval(1);      check_all("R4 gap0");
    // R5 overshoot past preset
    wait_ticks(40);  do_eval(1); check_all("R5 overshoot");
    chk("R5 done set", int'(done_o), 1);

    // R7 preset change between strobes leaves flags untouched
    do_write(2'd1, 16'h0FFF);
    repeat (20) @(negedge clk);
    chk("R7 done held", int'(done_o), 1);
    rd(2'd2, v); chk("R7 acc held", v, m_acc);
    do_eval(1); check_all("R7 re-evaluated");
    chk("R5 done cleared by preset", int'(done_o), 0);

    // R10 ignored writes
    do_write(2'd2, 16'h0ABC);
    rd(2'd2, v); chk("R10 acc write ignored", v, m_acc);
    do_write(2'd0, 16'h0000);
    rd(2'd0, v); chk("R10 ctrl write ignored", v, ctrl_exp());
    do_write(2'd3, 16'h1234);
    rd(2'd1, v); chk("R10 preset untouched", v, m_pre);

    // R6 disabled evaluation
    do_eval(0); check_all("R6 clear");

    // R9 aliasing over a gap longer than 255 ticks
    do_write(2'd1, 16'd500);
    do_eval(1); check_all("R9 start");
    wait_ticks(260); do_eval(1); check_all("R9 aliased");
    chk("R9 only 4 ticks", m_acc, 4);

    // R8 saturation
    do_write(2'd1, MAXV);
    for (int i = 0; i < 20; i++) begin
      wait_ticks(250); do_eval(1);
    end
    check_all("R8 saturate");
    chk("R8 at max", m_acc, MAXV);
    wait_ticks(100); do_eval(1); check_all("R8 stays max");

    // random scans
    do_eval(0);
    for (int i = 0; i < 80; i++) begin
      int g = $urandom_range(0, 300);
      if ($urandom_range(0, 5) == 0) do_write(2'd1, $urandom_range(0, 16'hFFFF));
      wait_ticks(g);
      do_eval($urandom_range(0, 7) != 0);
      check_all("R4/R5/R6 random");
    end

    finish_run();
  end
endmodule